// File: doc/BRIEF.md
# Debounced Hibernate Latch Controller

This block drives the close/open control of a switch that connects the cell to its load. A hibernate request input has to be seen high on every clock sample for a full qualification window before it takes effect. Once the window completes, a sticky latch is set and the switch is held open, whatever the cell voltage is. The only way out is an active-low wake input. One low sample on wake clears the latch.

While the latch is clear, the switch may close only when a low-cell comparator input reports that the cell is above its minimum charge level. The qualification window is counted on a free-running clock through a tick prescaler. The window length is `TICK_DIV * HOLD_TICKS` clock cycles. The defaults (1 and 1049) give about 32 ms at a 32.768 kHz clock. Every input is sampled synchronously on the rising clock edge. The comparator and the analog switch are outside the block.

Top module: `hib_latch_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until the first edge with cell_ok high, `switch_close` is 0 and the latch is clear. The reset state is non-hibernate.
- R2: With the latch clear, the value `switch_close` takes at each rising edge equals the `cell_ok` sampled at that edge (1 = cell above the low-charge level, 1 = switch closed).
- R3: The latch sets on the edge that takes the N-th consecutive high sample of `hib_req`, where N = TICK_DIV*HOLD_TICKS. A run of N-1 high samples followed by a low sample never sets it.
- R4: Any low sample of `hib_req` restarts the count from zero, so a fresh run of N high samples is needed after it.
- R5: While the latch is set, `switch_close` is 0 regardless of `cell_ok`.
- R6: The latch stays set after `hib_req` returns low, until `wake_n` is sampled low.
- R7: A single low sample of `wake_n` clears the latch. With `cell_ok` high, `switch_close` returns to 1 on the following edge.
- R8: A low sample of `wake_n` while `hib_req` is high blocks re-setting. The latch may set again only after `hib_req` has been sampled low and a new run of N high samples completes.
- R9: When `wake_n` is low on the same edge as the N-th high sample, the clear wins and the latch stays clear.
- R10: The switch output is registered. On the edge that sets the latch, `switch_close` still follows `cell_ok`. It opens on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hib_req | input | 1 | Hibernate request, active high, defaults low |
| wake_n | input | 1 | Active-low latch clear, defaults high |
| cell_ok | input | 1 | Comparator: 1 when the cell is above its low-charge level |
| switch_close | output | 1 | 1 closes the cell switch, 0 opens it |

## Verification
The bench sweeps every hold length from one sample to two beyond N, with a prescaler of 3 and 4 ticks. A counter that is off by one, or that tallies ticks instead of clock samples, sets the latch one edge early or never. A request that drops one sample short of the window and then resumes must not set the latch; a design that forgets to restart on the low sample would open the switch early. A wake pulse during a continuous request, and a wake pulse on the very edge of qualification, are both driven. A design that lets the request win, or that re-arms without a low sample, would open the switch again while the request is still high.

// File: rtl/hib_pkg.sv
package hib_pkg;

    // Registered control state of the latch controller.
    typedef struct packed {
        logic latched;   // hibernate override active
        logic armed;     // a qualified hold may set the latch
        logic sw;        // registered switch drive
    } hib_ctrl_t;

    localparam hib_ctrl_t HIB_CTRL_RST = '{latched: 1'b0, armed: 1'b1, sw: 1'b0};

endpackage

// File: rtl/hib_tick_div.sv
// Prescaler that produces a tick every TICK_DIV consecutive samples of run;
// it restarts whenever run is sampled low.
module hib_tick_div #(
    parameter int unsigned TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q == LAST);
        pre_d = pre_q;
        if (!run) begin
            pre_d = '0;
        end else if (pre_q == LAST) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/hib_hold_qual.sv
// Counts prescaler ticks of an unbroken high run; pulses hit on the tick that
// completes HOLD_TICKS, then saturates so a held request fires only once.
module hib_hold_qual #(
    parameter int unsigned HOLD_TICKS = 1049
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic hit
);
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);
    localparam logic [CW-1:0] PENULT = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = run && tick && (cnt_q == PENULT);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != FULL)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/hib_latch_ctrl.sv
module hib_latch_ctrl
    import hib_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 1,
    parameter int unsigned HOLD_TICKS = 1049
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hib_req,
    input  logic wake_n,
    input  logic cell_ok,
    output logic switch_close
);
    localparam int unsigned HOLD_CYCLES = TICK_DIV * HOLD_TICKS;

    logic      tick;
    logic      hold_hit;
    hib_ctrl_t ctrl_d, ctrl_q;

    // Observation points for the bound checker.
    logic        latched_w;
    logic [31:0] hold_len;

    hib_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hib_req),
        .tick  (tick)
    );

    hib_hold_qual #(.HOLD_TICKS(HOLD_TICKS)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hib_req),
        .tick  (tick),
        .hit   (hold_hit)
    );

    always_comb begin
        ctrl_d = ctrl_q;

        // Re-arm only on a low request sample; a clear during a high
        // request disarms until then.
        if (!hib_req) begin
            ctrl_d.armed = 1'b1;
        end else if (!wake_n) begin
            ctrl_d.armed = 1'b0;
        end

        // Clear has priority over a completing hold.
        if (!wake_n) begin
            ctrl_d.latched = 1'b0;
        end else if (hold_hit && ctrl_q.armed) begin
            ctrl_d.latched = 1'b1;
        end

        ctrl_d.sw = !ctrl_q.latched && cell_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= HIB_CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign switch_close = ctrl_q.sw;
    assign latched_w    = ctrl_q.latched;
    assign hold_len     = 32'(HOLD_CYCLES);

endmodule

// File: rtl/hib_latch_chk.sv
module hib_latch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hib_req,
    input logic        wake_n,
    input logic        cell_ok,
    input logic        switch_close,
    input logic        latched,
    input logic [31:0] hold_len
);
    // Independent run-length of consecutive high request samples.
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!hib_req) begin
            run_q <= '0;
        end else if (run_q != 32'hFFFF_FFFF) begin
            run_q <= run_q + 32'd1;
        end
    end

    a_r2_low_cell_open: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_ok |=> !switch_close);

    a_r2_close_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched && cell_ok) |=> switch_close);

    a_r5_latched_open: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> !switch_close);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_n |=> !latched);

    a_r4_no_set_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!hib_req && !latched) |=> !latched);

    a_r3_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> (run_q >= hold_len));

endmodule

bind hib_latch_ctrl hib_latch_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hib_req      (hib_req),
    .wake_n       (wake_n),
    .cell_ok      (cell_ok),
    .switch_close (switch_close),
    .latched      (latched_w),
    .hold_len     (hold_len)
);

// File: tb/hib_latch_ctrl_test.sv
module hib_latch_ctrl_test;
    localparam int unsigned TD = 3;
    localparam int unsigned HT = 4;
    localparam int N = TD * HT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hib_req = 1'b0;
    logic wake_n = 1'b1;
    logic cell_ok = 1'b0;
    logic switch_close;

    int checks = 0;
    int errors = 0;

    // Requirement-level model state.
    int   m_run = 0;
    logic m_latch = 1'b0;
    logic m_armed = 1'b1;
    logic exp_sw = 1'b0;

    always #2.5 clk = ~clk;

    hib_latch_ctrl #(.TICK_DIV(TD), .HOLD_TICKS(HT)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hib_req      (hib_req),
        .wake_n       (wake_n),
        .cell_ok      (cell_ok),
        .switch_close (switch_close)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: switch_close=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one sample from a negedge, advance through the posedge,
    // update the model, and compare at the following negedge.
    task automatic cyc(input logic h, input logic w, input logic c, input string tag);
        logic hit;
        hib_req = h;
        wake_n  = w;
        cell_ok = c;
        @(posedge clk);
        exp_sw = !m_latch && c;
        hit    = h && (m_run == N - 1);
        m_run  = h ? ((m_run == N) ? N : m_run + 1) : 0;
        if (!w) m_latch = 1'b0;
        else if (hit && m_armed) m_latch = 1'b1;
        if (!h) m_armed = 1'b1;
        else if (!w) m_armed = 1'b0;
        @(negedge clk);
        check(switch_close, exp_sw, tag);
    endtask

    initial begin
        #(1_000_000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, switch open
        repeat (3) @(negedge clk);
        check(switch_close, 1'b0, "R1");
        cell_ok = 1'b1;
        @(negedge clk);
        check(switch_close, 1'b0, "R1");
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, "R1");

        // R2: switch follows cell_ok while latch clear
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, i[0], "R2");

        // R3 / R10: sweep every hold length, then release and clear
        for (int l = 1; l <= N + 2; l++) begin
            for (int k = 1; k <= l; k++) cyc(1'b1, 1'b1, 1'b1, (k == N + 1) ? "R10" : "R3");
            cyc(1'b0, 1'b1, 1'b1, "R3");
            cyc(1'b0, 1'b1, 1'b1, (l >= N) ? "R6" : "R3");
            cyc(1'b0, 1'b0, 1'b1, "R7");
            cyc(1'b0, 1'b1, 1'b1, "R7");
        end

        // R4: N-1 high, one low, N-1 high: no set; one more sets
        for (int k = 0; k < N - 1; k++) cyc(1'b1, 1'b1, 1'b1, "R4");
        cyc(1'b0, 1'b1, 1'b1, "R4");
        for (int k = 0; k < N - 1; k++) cyc(1'b1, 1'b1, 1'b1, "R4");
        cyc(1'b1, 1'b1, 1'b1, "R4");
        cyc(1'b1, 1'b1, 1'b1, "R4");

        // R5: latched, cell_ok toggling, switch stays open
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, i[0], "R5");
        // R6: request dropped, latch holds
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, "R6");
        // R7: one-sample clear
        cyc(1'b0, 1'b0, 1'b1, "R7");
        cyc(1'b0, 1'b1, 1'b1, "R7");
        cyc(1'b0, 1'b1, 1'b1, "R7");

        // R8: clear during a continuous request
        for (int k = 0; k < N + 2; k++) cyc(1'b1, 1'b1, 1'b1, "R8");
        cyc(1'b1, 1'b0, 1'b1, "R8");
        for (int k = 0; k < 2 * N; k++) cyc(1'b1, 1'b1, 1'b1, "R8");
        cyc(1'b0, 1'b1, 1'b1, "R8");
        for (int k = 0; k < N + 2; k++) cyc(1'b1, 1'b1, 1'b1, "R8");
        cyc(1'b0, 1'b0, 1'b1, "R8");
        cyc(1'b0, 1'b1, 1'b1, "R8");

        // R8: clear early in the count also blocks this run
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b1, "R8");
        cyc(1'b1, 1'b0, 1'b1, "R8");
        for (int k = 0; k < N + 2; k++) cyc(1'b1, 1'b1, 1'b1, "R8");
        cyc(1'b0, 1'b1, 1'b1, "R8");

        // R9: clear on the qualifying edge wins
        for (int k = 0; k < N - 1; k++) cyc(1'b1, 1'b1, 1'b1, "R9");
        cyc(1'b1, 1'b0, 1'b1, "R9");
        for (int k = 0; k < N + 2; k++) cyc(1'b1, 1'b1, 1'b1, "R9");
        cyc(1'b0, 1'b1, 1'b1, "R9");

        // R2 with cell low while latch clear and request running
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b0, "R2");
        cyc(1'b0, 1'b1, 1'b1, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule